// File: doc/BRIEF.md
# Address-Line Serial Clock Register Unlocker

This block sits beside a ROM and watches the ROM's ordinary access strobes. Each access carries two address lines that matter to it: one line carries a data bit and another acts as an active-low write flag. A ROM read is turned into a "write" of one bit when the write flag is low, so software can send bits to the block simply by reading chosen ROM addresses. The block holds an 8-byte clock register file that it moves only in serial form, one bit per access.

While locked, the block compares every written bit against a fixed 64-bit key. A read restarts the comparison, and so does a wrong bit. When all 64 key bits have matched, the block enters data mode. In data mode each following access moves one register bit. A read returns the bit on data line 0, and a write supplies the bit on the address data line. After exactly 64 such accesses the block locks itself again. Written bits first go into a shadow copy, which replaces the register file in one step at the end of the transfer. Outside a data-mode read, the ROM byte passes through untouched.

Top module: `phantom_clock_tap`

## Requirements
- R1: An access (`acc_valid` high) with `acc_wr_n` low is a write whose bit is `acc_a0`. An access with `acc_wr_n` high is a read. Without `acc_valid` the pointer and the mode do not change.
- R2: A read while locked returns the match pointer to key bit 0. For example, 63 correct key bits, then a read, then key bit 63 leave the block locked.
- R3: The key is the bytes C5, 3A, A3, 5C, C5, 3A, A3, 5C, sent in that order with each byte least-significant bit first (key bit n is bit n%8 of byte n/8). When the 64th bit matches, the block enters data mode at register bit 0.
- R4: A written bit that differs from the expected key bit returns the pointer to 0 and leaves the block locked.
- R5: A read in data mode returns register bit k on `rom_out[0]` and `rom_in[7:1]` on `rom_out[7:1]`. Here k counts 0 to 63 over the transfer, and bit k is bit k%8 of register byte k/8.
- R6: A write in data mode stores `acc_a0` as register bit k, in the same order as reads. All 64 bits take effect together when the transfer ends, and bits that were read rather than written keep their old value.
- R7: After the 64th data-mode access the block is locked and needs a full new key.
- R8: When the access is not a data-mode read, `rom_out` equals `rom_in`.
- R9: A synchronous active-high `rst` clears the pointer, locks the block and sets all 64 register bits to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | One ROM access this cycle |
| acc_wr_n | input | 1 | Address line used as active-low write flag |
| acc_a0 | input | 1 | Address line carrying the written bit |
| rom_in | input | 8 | Data byte from the ROM |
| rom_out | output | 8 | Data byte returned to the bus |

## Verification
The assertions assume that each access is presented for exactly one cycle with `acc_valid` and that the address lines are stable while it is high. They also assume that reset is held for at least one edge before any access. The bench drives every access as a single-cycle strobe set just after a clock edge and drops `acc_valid` between groups of accesses. Read results are checked against a bench-side model of the register file. The stimulus covers key sequences that a read or a wrong bit breaks, as well as sessions that mix writes and reads.

// File: rtl/phantom_clock_tap.sv
module phantom_clock_tap #(
  parameter int BYTES  = 8,
  parameter int BYTE_W = 8,
  parameter logic [BYTES*BYTE_W-1:0] UNLOCK_KEY = 64'h5CA3_3AC5_5CA3_3AC5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_wr_n,
  input  logic              acc_a0,
  input  logic [BYTE_W-1:0] rom_in,
  output logic [BYTE_W-1:0] rom_out
);
  localparam int NBITS = BYTES * BYTE_W;
  localparam int PTR_W = $clog2(NBITS);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NBITS - 1);

  logic             live;
  logic [PTR_W-1:0] pos;
  logic [NBITS-1:0] regfile, shadow, shadow_nx;

  wire rd_hit = acc_valid & acc_wr_n & live;
  wire wr_hit = acc_valid & ~acc_wr_n & live;

  assign rom_out = rd_hit ? {rom_in[BYTE_W-1:1], regfile[pos]} : rom_in;

  always_comb begin
    shadow_nx = shadow;
    if (wr_hit) shadow_nx[pos] = acc_a0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live    <= 1'b0;
      pos     <= '0;
      regfile <= '0;
      shadow  <= '0;
    end else if (acc_valid) begin
      if (!live) begin
        if (acc_wr_n) begin
          pos <= '0;
        end else if (acc_a0 == UNLOCK_KEY[pos]) begin
          if (pos == LAST) begin
            live   <= 1'b1;
            pos    <= '0;
            shadow <= regfile;
          end else begin
            pos <= pos + 1'b1;
          end
        end else begin
          pos <= '0;
        end
      end else begin
        shadow <= shadow_nx;
        if (pos == LAST) begin
          live    <= 1'b0;
          pos     <= '0;
          regfile <= shadow_nx;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/phantom_clock_tap_chk.sv
module phantom_clock_tap_chk #(
  parameter int BYTE_W = 8,
  parameter int NBITS  = 64,
  parameter int PTR_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_wr_n,
  input logic [BYTE_W-1:0] rom_in,
  input logic [BYTE_W-1:0] rom_out,
  input logic              live,
  input logic [PTR_W-1:0]  pos,
  input logic [NBITS-1:0]  regfile
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NBITS - 1);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> !live && pos == '0 && regfile == '0); // R9

  AST_NOACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> $stable(pos) && $stable(live)); // R1

  AST_IDLE_READ_CLR: assert property (@(posedge clk) disable iff (rst)
    (!live && acc_valid && acc_wr_n) |=> (pos == '0 && !live)); // R2

  AST_ENTRY_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(live) |-> pos == '0); // R3

  AST_LIVE_STEP: assert property (@(posedge clk) disable iff (rst)
    (live && acc_valid && pos != LAST) |=> (live && pos == $past(pos) + PTR_W'(1))); // R5

  AST_READ_UPPER: assert property (@(posedge clk) disable iff (rst)
    (live && acc_valid && acc_wr_n) |-> rom_out[BYTE_W-1:1] == rom_in[BYTE_W-1:1]); // R5

  AST_FILE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(live && acc_valid && pos == LAST) |=> $stable(regfile)); // R6

  AST_END_LOCKS: assert property (@(posedge clk) disable iff (rst)
    (live && acc_valid && pos == LAST) |=> (!live && pos == '0)); // R7

  AST_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    !(live && acc_valid && acc_wr_n) |-> rom_out == rom_in); // R8
endmodule

bind phantom_clock_tap phantom_clock_tap_chk #(
  .BYTE_W(BYTE_W), .NBITS(NBITS), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_wr_n(acc_wr_n),
  .rom_in(rom_in), .rom_out(rom_out), .live(live), .pos(pos), .regfile(regfile)
);

// File: tb/phantom_clock_tap_tb.sv
module phantom_clock_tap_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] KEY = {8'h5C, 8'hA3, 8'h3A, 8'hC5, 8'h5C, 8'hA3, 8'h3A, 8'hC5};

  logic clk = 1'b0, rst = 1'b1;
  logic acc_valid = 1'b0, acc_wr_n = 1'b1, acc_a0 = 1'b0;
  logic [7:0] rom_in = 8'h00, rom_out;

  int checks = 0, errors = 0;
  logic [63:0] model = '0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];

  phantom_clock_tap u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_wr_n(acc_wr_n),
    .acc_a0(acc_a0), .rom_in(rom_in), .rom_out(rom_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      if (acc_valid && acc_wr_n) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL unexpected read, actual %h expected none", rom_out);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (rom_out !== e) begin
            errors++;
            $display("FAIL %s actual %h expected %h", t, rom_out, e);
          end
        end
      end else begin
        checks++;
        if (rom_out !== rom_in) begin
          errors++;
          $display("FAIL R8 passthrough actual %h expected %h", rom_out, rom_in);
        end
      end
    end
  end

  task automatic acc(input logic wn, input logic a0, input logic [7:0] rom,
                     input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    acc_valid = 1'b1; acc_wr_n = wn; acc_a0 = a0; rom_in = rom;
    if (wn) begin exp_q.push_back(exp); tag_q.push_back(tag); end
  endtask

  task automatic idle();
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_wr_n = 1'b1; rom_in = 8'h69;
  endtask

  task automatic unlock();
    for (int i = 0; i < 64; i++) acc(1'b0, KEY[i], 8'h3C, 8'h00, "R3");
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 64; i++) begin
      logic [7:0] r;
      r = 8'(i * 37 + 1);
      acc(1'b1, 1'b0, r, {r[7:1], model[i]}, tag);
    end
  endtask

  task automatic write_all(input logic [63:0] v);
    for (int i = 0; i < 64; i++) acc(1'b0, v[i], 8'h5A, 8'h00, "R6");
    model = v;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    idle();
    acc(1'b1, 1'b0, 8'hA5, 8'hA5, "R9 locked after reset");
    unlock();
    read_all("R9 R3 R5 zero file after reset");
    acc(1'b1, 1'b0, 8'hFF, 8'hFF, "R7 locked after 64 reads");
    idle();

    unlock();
    write_all(64'hDEAD_BEEF_0123_4567);
    acc(1'b1, 1'b0, 8'hFF, 8'hFF, "R7 locked after 64 writes");
    unlock();
    read_all("R1 R6 written file read back");
    idle();

    unlock();
    for (int i = 0; i < 8; i++) acc(1'b0, 1'(8'h96 >> i), 8'h11, 8'h00, "R6");
    for (int i = 8; i < 64; i++) acc(1'b1, 1'b0, 8'hFE, {7'h7F, model[i]}, "R6 old bits during session");
    model[7:0] = 8'h96;
    unlock();
    read_all("R6 whole-file commit");
    idle();

    for (int i = 0; i < 63; i++) acc(1'b0, KEY[i], 8'h00, 8'h00, "R2");
    acc(1'b1, 1'b0, 8'hFF, 8'hFF, "R2 read while locked");
    acc(1'b0, KEY[63], 8'h00, 8'h00, "R2");
    acc(1'b1, 1'b0, 8'hFF, 8'hFF, "R2 pointer restarted");
    idle();

    for (int i = 0; i < 20; i++) acc(1'b0, KEY[i], 8'h00, 8'h00, "R4");
    acc(1'b0, ~KEY[20], 8'h00, 8'h00, "R4");
    for (int i = 21; i < 64; i++) acc(1'b0, KEY[i], 8'h00, 8'h00, "R4");
    acc(1'b1, 1'b0, 8'hFF, 8'hFF, "R4 wrong bit keeps locked");
    idle();

    unlock();
    read_all("R5 file intact after failed keys");
    idle();
    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R5 pending reads actual %0d expected 0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule